// File: doc/BRIEF.md
# Protected Register Write Guard

This block keeps a critical control value, here a clock-divider select, safe from stray bus writes. It sits on a simple synchronous register bus with an address, a write strobe, write data, a read strobe and registered read data. Software must first write any value to a command (key) location. Only the bus write that comes next may change the guarded select register. A guarded write that comes in any other order is dropped, and a sticky protection-error flag is raised.

The guarded value drives the `clk_sel` output directly. Reads are never restricted, and read cycles or idle cycles between the key write and the guarded write do not break the sequence. Only another write breaks it. The error flag sits in a status location that has no protection. Writing 0 to its bit 0 clears the flag.

Address map, with a default `ADDR_W` of 4: key = 0x0, select = 0x1, status = 0x2. Every other address is unmapped. A write to an unmapped address is ignored, but it still counts as a write. A read from an unmapped address returns 0.

Top module: `prot_reg_guard`

## Requirements
- R1: After reset, `clk_sel` equals `SEL_RESET`, which defaults to 3'b111. `prot_err` is 0, the unlock is cleared and `bus_rdata` is 0.
- R2: A write of any data to the key address (0x0) arms the unlock. A read of the key address returns 0.
- R3: When the select address (0x1) is written as the first bus write after the key write, bits [SEL_W-1:0] of the write data appear on `clk_sel` one cycle after that write.
- R4: When any other write comes between the key write and the select write, at any address including status or unmapped ones, the select write is dropped. `clk_sel` keeps its value and `prot_err` becomes 1 one cycle after the dropped write.
- R5: A write to the select address with no unlock armed is dropped and sets `prot_err`.
- R6: Every bus write disarms the unlock, whether the write is accepted or not. The only exception is a write to the key address, which arms it again. Each unlock therefore allows at most one select write.
- R7: `prot_err` is sticky. A write to the status address (0x2) with bit 0 = 0 clears it one cycle later. A status write with bit 0 = 1 leaves it unchanged. Status writes need no unlock.
- R8: Reads of the select address always return the current `clk_sel` value. Read and idle cycles between the key write and the select write do not break the sequence.
- R9: `bus_rdata` is registered. One cycle after `bus_rd` is high it shows the addressed value: select = `clk_sel` zero-extended, status = `prot_err` in bit 0 with zeros above it, others = 0. When `bus_rd` is low, `bus_rdata` holds its value.
- R10: `clk_sel` changes only in the cycle after an accepted select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| clk_sel | output | SEL_W | Guarded clock-divider select |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
Every result of this block is due exactly one rising edge after the bus cycle that causes it. A new `clk_sel` value, a set or cleared `prot_err` and fresh `bus_rdata` all appear at that edge. A key write changes nothing that can be seen until the following write is judged. The bench drives the bus at falling edges and updates a behavioural model at each rising edge. At the next falling edge it compares all three outputs with that model, so every comparison falls in the first cycle a result is valid. Directed checks at the end of each scenario name the requirement under test.

// File: rtl/prot_guard_pkg.sv
// Package: shared address map of the protected register write guard.
// Assumes: the address bus is at least two bits wide.
package prot_guard_pkg;
    localparam int unsigned OFS_KEY  = 0;  // key location, data ignored
    localparam int unsigned OFS_SEL  = 1;  // guarded select register
    localparam int unsigned OFS_STAT = 2;  // status, bit 0 = protection error
    localparam int unsigned ERR_BIT  = 0;
endpackage

// File: rtl/unlock_tracker.sv
// Module: unlock_tracker
// Holds the one-shot unlock. A key write arms it; any other write disarms it.
// Assumes: at most one write per cycle; reads never reach this module.
module unlock_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic wr_key,
    output logic armed
);
    // Arm on a key write, drop on any other write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_any) begin
            armed <= wr_key;
        end
    end
endmodule

// File: rtl/guarded_sel_reg.sv
// Module: guarded_sel_reg
// Stores the guarded select value. A write lands only while unlocked;
// otherwise the write is reported as rejected in the same cycle.
// Assumes: armed reflects only writes made before this cycle.
module guarded_sel_reg #(
    parameter int unsigned SEL_W     = 3,
    parameter logic [SEL_W-1:0] SEL_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             armed,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             reject
);
    // A select write without a live unlock is a protection violation.
    always_comb reject = wr_sel && !armed;

    // Load the new value only on an unlocked select write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_RESET;
        end else if (wr_sel && armed) begin
            sel_q <= wdata;
        end
    end
endmodule

// File: rtl/sticky_err.sv
// Module: sticky_err
// Sticky error flag: set by a rejected write, cleared only by an explicit
// clear request or by reset.
// Assumes: set and clear never coincide (they come from different addresses).
module sticky_err (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic err
);
    // Set wins over hold; clear is honoured only when no set is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (set) begin
            err <= 1'b1;
        end else if (clr) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/prot_reg_guard.sv
// Module: prot_reg_guard (top)
// Bus-attached guard for a clock-divider select register. Decodes the
// bus, sequences the unlock, holds the guarded value and the sticky error,
// and returns registered read data.
// Assumes: single-cycle bus strobes, one access of each kind per cycle.
module prot_reg_guard
    import prot_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SEL_W     = 3,
    parameter logic [SEL_W-1:0] SEL_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              prot_err
);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic wr_key, wr_sel, wr_clr;
    logic armed_q;
    logic sel_reject;

    // Write address decode.
    always_comb begin
        wr_key = bus_wr && (bus_addr == A_KEY);
        wr_sel = bus_wr && (bus_addr == A_SEL);
        wr_clr = bus_wr && (bus_addr == A_STAT) && !bus_wdata[ERR_BIT];
    end

    unlock_tracker u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_any (bus_wr),
        .wr_key (wr_key),
        .armed  (armed_q)
    );

    guarded_sel_reg #(
        .SEL_W     (SEL_W),
        .SEL_RESET (SEL_RESET)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .armed  (armed_q),
        .wdata  (bus_wdata[SEL_W-1:0]),
        .sel_q  (clk_sel),
        .reject (sel_reject)
    );

    sticky_err u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sel_reject),
        .clr   (wr_clr),
        .err   (prot_err)
    );

    // Registered read mux; the key location and unmapped space read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                A_SEL:   bus_rdata <= DATA_W'(clk_sel);
                A_STAT:  bus_rdata <= DATA_W'(prot_err);
                default: bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/prot_guard_checker.sv
// Module: prot_guard_checker
// Temporal properties of the guard, attached to the top through bind.
module prot_guard_checker
    import prot_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SEL_W-1:0]  clk_sel,
    input logic              prot_err,
    input logic              armed
);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_KEY) |=> armed);

    assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_KEY) |=> (bus_rdata == '0));

    assert_locked_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SEL && !armed) |=> (prot_err && $stable(clk_sel)));

    assert_write_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_KEY) |=> !armed);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !(bus_wr && bus_addr == A_STAT && !bus_wdata[ERR_BIT])) |=> prot_err);

    assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_SEL) |=> $stable(clk_sel));
endmodule

bind prot_reg_guard prot_guard_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .clk_sel   (clk_sel),
    .prot_err  (prot_err),
    .armed     (armed_q)
);

// File: tb/tb_prot_reg_guard.sv
// Bench: behavioural reference model, compared with the outputs at every
// falling edge; directed checks at the end of each scenario.
module tb_prot_reg_guard;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int K = 0, S = 1, T = 2, U = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [SEL_W-1:0]  clk_sel;
    logic              prot_err;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Reference model state
    int  m_sel = 7;
    bit  m_err = 0;
    bit  m_armed = 0;
    int  m_rdata = 0;

    always #2.5 clk = ~clk;

    prot_reg_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .clk_sel(clk_sel), .prot_err(prot_err)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        int a;
        a = int'(bus_addr);
        if (!rst_n) begin
            m_sel = 7; m_err = 0; m_armed = 0; m_rdata = 0;
        end else begin
            if (bus_rd) begin
                if (a == S)      m_rdata = m_sel;
                else if (a == T) m_rdata = int'(m_err);
                else             m_rdata = 0;
            end
            if (bus_wr) begin
                if (a == S) begin
                    if (m_armed) m_sel = int'(bus_wdata) % 8;
                    else         m_err = 1;
                end else if (a == T && bus_wdata[0] == 1'b0) begin
                    m_err = 0;
                end
                m_armed = (a == K);
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Continuous comparison at each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "clk_sel", int'(clk_sel), m_sel);
            check(cur_req, "prot_err", int'(prot_err), int'(m_err));
            check(cur_req, "bus_rdata", int'(bus_rdata), m_rdata);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
                done = 1'b1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none

        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        check("R1", "clk_sel", int'(clk_sel), 7);
        check("R1", "prot_err", int'(prot_err), 0);
        check("R1", "bus_rdata", int'(bus_rdata), 0);

        // R2, R3: key with arbitrary data, then select write
        cur_req = "R3";
        wr(K, 8'hA5); wr(S, 2);
        check("R3", "clk_sel", int'(clk_sel), 2);
        cur_req = "R2";
        rd(K);
        check("R2", "key readback", int'(bus_rdata), 0);

        // R8: reads and idle between unlock and select write
        cur_req = "R8";
        wr(K, 0); rd(S); check("R8", "sel readback", int'(bus_rdata), 2);
        rd(T); idle(2); wr(S, 5);
        check("R8", "clk_sel", int'(clk_sel), 5);
        check("R8", "prot_err", int'(prot_err), 0);

        // R4: status write breaks sequence
        cur_req = "R4";
        wr(K, 1); wr(T, 1); wr(S, 1);
        check("R4", "clk_sel kept", int'(clk_sel), 5);
        check("R4", "prot_err", int'(prot_err), 1);
        // R7: writing 1 keeps the flag, writing 0 clears it
        cur_req = "R7";
        wr(T, 8'hFF); check("R7", "err kept", int'(prot_err), 1);
        rd(T); check("R7", "status read", int'(bus_rdata), 1);
        wr(T, 8'hFE); check("R7", "err cleared", int'(prot_err), 0);

        // R4: unmapped write breaks sequence
        cur_req = "R4";
        wr(K, 3); wr(U, 9); wr(S, 6);
        check("R4", "clk_sel kept", int'(clk_sel), 5);
        check("R4", "prot_err", int'(prot_err), 1);
        wr(T, 0);

        // R5: select write with no unlock
        cur_req = "R5";
        wr(S, 0);
        check("R5", "clk_sel kept", int'(clk_sel), 5);
        check("R5", "prot_err", int'(prot_err), 1);
        wr(T, 0);

        // R6: one unlock allows one write; repeated key re-arms
        cur_req = "R6";
        wr(K, 0); wr(S, 4); wr(S, 6);
        check("R6", "clk_sel", int'(clk_sel), 4);
        check("R6", "prot_err", int'(prot_err), 1);
        wr(T, 0);
        wr(K, 0); wr(K, 7); wr(S, 8'hF8);
        check("R6", "rearm accept", int'(clk_sel), 0);

        // R9, R10: readback holds, high bits dropped, unmapped read zero
        cur_req = "R9";
        rd(S); check("R9", "sel readback", int'(bus_rdata), 0);
        wr(K, 0); wr(S, 8'h0B); rd(S);
        check("R10", "clk_sel", int'(clk_sel), 3);
        idle(2); check("R9", "rdata hold", int'(bus_rdata), 3);
        rd(U); check("R9", "unmapped read", int'(bus_rdata), 0);

        // R1: reset while armed
        cur_req = "R1";
        wr(K, 0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1", "clk_sel", int'(clk_sel), 7);
        wr(S, 1);
        check("R1", "unlock cleared", int'(clk_sel), 7);
        check("R1", "prot_err", int'(prot_err), 1);

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule